// File: doc/BRIEF.md
# Frame-rate bucket classifier

This block watches an audio frame-sync signal and measures its period in cycles of a free-running reference clock. Each completed period is compared against a fixed set of sample-rate windows. The result is a small numeric rate code and a valid flag. A tolerance input switches between a tight window set and a looser one. The raw measured period is also brought out so that software can read the true incoming timing.

Lock is declared only when two back-to-back periods land in the same window. A period that fits no window, or a frame-sync that stops long enough for the counter to saturate, drops the lock immediately. A sticky clock-error flag records every loss of lock and every relock at a different rate, and it stays set until a one-cycle clear pulse. Window limits are held as cycle counts. They are worked out at elaboration from the reference frequency parameter, so a faster rate maps to a smaller count.

Top module: `fsync_rate_sorter`

## Requirements
- R1: While reset is asserted and right after it, `rate_valid`, `rate_code`, `clk_err` and `period_cnt` are all zero.
- R2: The frame-sync input passes through a two-stage synchroniser, and its rising edges are detected. The first rising edge after reset only starts the counter. Each later edge loads `period_cnt` with the number of reference cycles since the previous edge.
- R3: With `tol_wide` low, a period is in a window when the rate REF_HZ/period lies between the limits below. The limits are in kHz, given as low/high and then the code. 3 kHz: 2.73/3.03, code 40. 4.8 kHz: 4.37/4.85, code 37. 8 kHz: 7.28/8.08, code 33. 12 kHz: 10.91/12.12, code 30. 16 kHz: 14.55/16.16, code 28. 24 kHz: 21.83/24.24, code 25. 32 kHz: 29.11/32.32, code 23. 48 kHz: 43.66/48.48, code 20. 96 kHz: 87.32/96.96, code 15. 192 kHz: 174.64/193.92, code 10. 384 kHz: 349.27/387.84, code 5. 768 kHz: 698.54/775.68, code 1.
- R4: `rate_code` only ever holds 0 or one of the codes listed in R3, and it holds 0 whenever `rate_valid` is low.
- R5: With `tol_wide` high, the windows are as follows, in kHz, with the same codes as R3. 4.8: 4.19/5.04. 8: 6.98/8.40. 12: 10.47/12.60. 16: 13.97/16.80. 24: 20.95/25.20. 32: 27.93/33.60. 48: 41.90/50.40. 96: 83.79/100.80. 192: 167.58/201.60. 384: 335.16/403.20. 768: 670.32/806.40. The 3 kHz window does not exist in this mode.
- R6: `rate_valid` goes high, with its code, only when two consecutive measured periods fall in the same window. A period in a different window from the one before clears `rate_valid` and `rate_code`. Between period events the outputs hold.
- R7: A period outside every window clears `rate_valid` and `rate_code` and sets `clk_err`. So does a saturated count. This includes the moment the counter saturates while no edge has arrived.
- R8: `clk_err` is set when a new lock carries a code different from the previous lock. The first lock after reset does not set it.
- R9: `clk_err` stays set until `err_clr` is high on a clock edge. A set on the same edge wins over the clear.
- R10: `tol_wide` is sampled at each period event, so the same period can be accepted in one mode and rejected in the other.
- R11: The period counter saturates at 2^CNT_W-1. With the defaults that is 16383, and `period_cnt` then reads 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, frequency REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_in | input | 1 | Asynchronous frame-sync input |
| tol_wide | input | 1 | 0 selects narrow windows, 1 selects wide windows |
| err_clr | input | 1 | Clears the sticky clock-error flag |
| rate_valid | output | 1 | Locked rate available |
| rate_code | output | 6 | Rate code of the locked window, 0 when not locked |
| clk_err | output | 1 | Sticky clock-error flag |
| period_cnt | output | CNT_W | Last measured period in reference cycles |

## Verification
Some rules are checked by the bound checker on every cycle. Outputs only move on a period or saturation event. The code is zero whenever lock is absent and is always a legal value. The error flag is sticky, and it rises only as a result of an event. Saturation leaves the block unlocked and flagged. Other behaviour only shows up through the bench's frame trains: where each window edge falls in cycle counts, the two-period lock rule, the change-of-rate error, the missing 3 kHz window in wide mode, and the mode-dependent acceptance of one period. The bench checks these against a reference model built from the window tables.

// File: rtl/rate_sort_pkg.sv
package rate_sort_pkg;

   localparam int NUM_BKT = 12;
   localparam int CODE_W  = 6;

   typedef logic [CODE_W-1:0] rate_code_t;

   // bucket index 0 is the fastest rate, NUM_BKT-1 the slowest
   // limits are expressed in units of 10 Hz
   function automatic int unsigned bkt_fmin10(input int idx, input bit wide);
      case (idx)
         0:       return wide ? 67032 : 69854;
         1:       return wide ? 33516 : 34927;
         2:       return wide ? 16758 : 17464;
         3:       return wide ? 8379  : 8732;
         4:       return wide ? 4190  : 4366;
         5:       return wide ? 2793  : 2911;
         6:       return wide ? 2095  : 2183;
         7:       return wide ? 1397  : 1455;
         8:       return wide ? 1047  : 1091;
         9:       return wide ? 698   : 728;
         10:      return wide ? 419   : 437;
         11:      return 273;
         default: return 1;
      endcase
   endfunction

   function automatic int unsigned bkt_fmax10(input int idx, input bit wide);
      case (idx)
         0:       return wide ? 80640 : 77568;
         1:       return wide ? 40320 : 38784;
         2:       return wide ? 20160 : 19392;
         3:       return wide ? 10080 : 9696;
         4:       return wide ? 5040  : 4848;
         5:       return wide ? 3360  : 3232;
         6:       return wide ? 2520  : 2424;
         7:       return wide ? 1680  : 1616;
         8:       return wide ? 1260  : 1212;
         9:       return wide ? 840   : 808;
         10:      return wide ? 504   : 485;
         11:      return 303;
         default: return 1;
      endcase
   endfunction

   function automatic rate_code_t bkt_code(input int idx);
      case (idx)
         0:       return 6'd1;
         1:       return 6'd5;
         2:       return 6'd10;
         3:       return 6'd15;
         4:       return 6'd20;
         5:       return 6'd23;
         6:       return 6'd25;
         7:       return 6'd28;
         8:       return 6'd30;
         9:       return 6'd33;
         10:      return 6'd37;
         11:      return 6'd40;
         default: return 6'd0;
      endcase
   endfunction

   // the slowest bucket only exists in the narrow set
   function automatic bit bkt_in_wide(input int idx);
      return idx < NUM_BKT - 1;
   endfunction

   // smallest cycle count for a rate ceiling
   function automatic longint unsigned cnt_lo(input longint unsigned ref_hz,
                                              input int unsigned fmax10);
      return (ref_hz + 64'(fmax10) * 10 - 1) / (64'(fmax10) * 10);
   endfunction

   // largest cycle count for a rate floor
   function automatic longint unsigned cnt_hi(input longint unsigned ref_hz,
                                              input int unsigned fmin10);
      return ref_hz / (64'(fmin10) * 10);
   endfunction

endpackage

// File: rtl/fsync_sync_edge.sv
module fsync_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("fsync_sync_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/frame_period_meter.sv
module frame_period_meter #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             cap_stb,
   output logic             tmo_stb,
   output logic [CNT_W-1:0] meas
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (rise) begin
         cnt_q   <= CNT_W'(1);
         armed_q <= 1'b1;
      end else if (armed_q && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cap_stb = rise & armed_q;
   // the counter is about to saturate with no edge seen
   assign tmo_stb = armed_q & ~rise & (cnt_q == CNT_MAX - CNT_W'(1));
   assign meas    = tmo_stb ? CNT_MAX : cnt_q;

endmodule

// File: rtl/rate_bucket_match.sv
module rate_bucket_match
   import rate_sort_pkg::*;
#(
   parameter int              CNT_W  = 14,
   parameter longint unsigned REF_HZ = 64'd24_576_000
) (
   input  logic [CNT_W-1:0] meas,
   input  logic             wide,
   output rate_code_t       code
);

   logic [NUM_BKT-1:0] hit_n;
   logic [NUM_BKT-1:0] hit_w;
   logic [NUM_BKT-1:0] hit_sel;

   for (genvar i = 0; i < NUM_BKT; i++) begin : g_bkt
      localparam longint unsigned NLO = cnt_lo(REF_HZ, bkt_fmax10(i, 1'b0));
      localparam longint unsigned NHI = cnt_hi(REF_HZ, bkt_fmin10(i, 1'b0));

      assign hit_n[i] = (64'(meas) >= NLO) && (64'(meas) <= NHI);

      if (bkt_in_wide(i)) begin : g_wide
         localparam longint unsigned WLO = cnt_lo(REF_HZ, bkt_fmax10(i, 1'b1));
         localparam longint unsigned WHI = cnt_hi(REF_HZ, bkt_fmin10(i, 1'b1));
         assign hit_w[i] = (64'(meas) >= WLO) && (64'(meas) <= WHI);
      end else begin : g_narrow_only
         assign hit_w[i] = 1'b0;
      end
   end

   assign hit_sel = wide ? hit_w : hit_n;

   // windows do not overlap; lowest index wins if they ever did
   always_comb begin
      code = '0;
      for (int i = NUM_BKT - 1; i >= 0; i--) begin
         if (hit_sel[i]) code = bkt_code(i);
      end
   end

endmodule

// File: rtl/rate_lock_tracker.sv
module rate_lock_tracker
   import rate_sort_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_stb,
   input  logic             tmo_stb,
   input  rate_code_t       cls_code,
   input  logic [CNT_W-1:0] meas,
   input  logic             err_clr,
   output logic             rate_valid,
   output rate_code_t       rate_code,
   output logic             clk_err,
   output logic [CNT_W-1:0] period_cnt
);

   rate_code_t cand_q;
   rate_code_t last_lock_q;
   rate_code_t cls_eff;
   logic       evt;
   logic       err_set;

   assign evt     = cap_stb | tmo_stb;
   assign cls_eff = tmo_stb ? '0 : cls_code;

   always_comb begin
      err_set = 1'b0;
      if (evt) begin
         if (cls_eff == '0) begin
            err_set = 1'b1;
         end else if (cls_eff == cand_q && last_lock_q != '0 && last_lock_q != cls_eff) begin
            err_set = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_valid  <= 1'b0;
         rate_code   <= '0;
         cand_q      <= '0;
         last_lock_q <= '0;
         period_cnt  <= '0;
      end else if (evt) begin
         period_cnt <= meas;
         if (cls_eff == '0) begin
            rate_valid <= 1'b0;
            rate_code  <= '0;
            cand_q     <= '0;
         end else if (cls_eff == cand_q) begin
            rate_valid  <= 1'b1;
            rate_code   <= cls_eff;
            last_lock_q <= cls_eff;
         end else begin
            cand_q     <= cls_eff;
            rate_valid <= 1'b0;
            rate_code  <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_err <= 1'b0;
      else        clk_err <= err_set | (clk_err & ~err_clr);
   end

endmodule

// File: rtl/fsync_rate_sorter.sv
module fsync_rate_sorter
   import rate_sort_pkg::*;
#(
   parameter longint unsigned REF_HZ      = 64'd24_576_000,
   parameter int              CNT_W       = 14,
   parameter int              SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_in,
   input  logic             tol_wide,
   input  logic             err_clr,
   output logic             rate_valid,
   output logic [5:0]       rate_code,
   output logic             clk_err,
   output logic [CNT_W-1:0] period_cnt
);

   localparam longint unsigned CNT_MAX_L  = (64'd1 << CNT_W) - 1;
   localparam longint unsigned SLOW_CNT   = cnt_hi(REF_HZ, bkt_fmin10(NUM_BKT - 1, 1'b0));
   localparam longint unsigned FAST_CNT   = cnt_lo(REF_HZ, bkt_fmax10(0, 1'b1));

   if (SLOW_CNT >= CNT_MAX_L) begin : g_bad_width
      $error("fsync_rate_sorter: CNT_W too small for slowest window");
   end
   if (FAST_CNT < 64'd16) begin : g_bad_ref
      $error("fsync_rate_sorter: REF_HZ too low to resolve fastest window");
   end
   if (CODE_W != 6) begin : g_bad_code
      $error("fsync_rate_sorter: code width mismatch");
   end

   logic             rise;
   logic             cap_stb;
   logic             tmo_stb;
   logic [CNT_W-1:0] meas;
   rate_code_t       cls_code;
   rate_code_t       code_q;

   fsync_sync_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (fsync_in),
      .rise     (rise)
   );

   frame_period_meter #(
      .CNT_W (CNT_W)
   ) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .cap_stb (cap_stb),
      .tmo_stb (tmo_stb),
      .meas    (meas)
   );

   rate_bucket_match #(
      .CNT_W  (CNT_W),
      .REF_HZ (REF_HZ)
   ) u_match (
      .meas (meas),
      .wide (tol_wide),
      .code (cls_code)
   );

   rate_lock_tracker #(
      .CNT_W (CNT_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_stb    (cap_stb),
      .tmo_stb    (tmo_stb),
      .cls_code   (cls_code),
      .meas       (meas),
      .err_clr    (err_clr),
      .rate_valid (rate_valid),
      .rate_code  (code_q),
      .clk_err    (clk_err),
      .period_cnt (period_cnt)
   );

   assign rate_code = code_q;

endmodule

// File: rtl/rate_sort_chk.sv
module rate_sort_chk #(
   parameter int CNT_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             err_clr,
   input logic             rate_valid,
   input logic [5:0]       rate_code,
   input logic             clk_err,
   input logic [CNT_W-1:0] period_cnt,
   input logic             cap_stb,
   input logic             tmo_stb
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |-> (!rate_valid && rate_code == 6'd0 && !clk_err && period_cnt == '0));

   p_zero_code_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rate_valid |-> rate_code == 6'd0);

   p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rate_valid |-> (rate_code inside {6'd1, 6'd5, 6'd10, 6'd15, 6'd20, 6'd23,
                                        6'd25, 6'd28, 6'd30, 6'd33, 6'd37, 6'd40}));

   p_hold_between_events_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_stb || tmo_stb) |=> ($stable(rate_valid) && $stable(rate_code) && $stable(period_cnt)));

   p_lock_needs_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rate_valid) |-> $past(cap_stb));

   p_saturation_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_stb |=> (!rate_valid && clk_err && period_cnt == CNT_MAX));

   p_err_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_err) |-> $past(cap_stb || tmo_stb));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_err && !err_clr) |=> clk_err);

endmodule

bind fsync_rate_sorter rate_sort_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .err_clr    (err_clr),
   .rate_valid (rate_valid),
   .rate_code  (rate_code),
   .clk_err    (clk_err),
   .period_cnt (period_cnt),
   .cap_stb    (cap_stb),
   .tmo_stb    (tmo_stb)
);

// File: tb/sim_fsync_rate_sorter.sv
`timescale 1ns/1ps
module sim_fsync_rate_sorter;

   localparam longint REF   = 64'd24_576_000;
   localparam int     CW    = 14;
   localparam int     MAXC  = (1 << CW) - 1;

   localparam int NLO [12] = '{69854, 34927, 17464, 8732, 4366, 2911, 2183, 1455, 1091, 728, 437, 273};
   localparam int NHI [12] = '{77568, 38784, 19392, 9696, 4848, 3232, 2424, 1616, 1212, 808, 485, 303};
   localparam int WLO [12] = '{67032, 33516, 16758, 8379, 4190, 2793, 2095, 1397, 1047, 698, 419, 0};
   localparam int WHI [12] = '{80640, 40320, 20160, 10080, 5040, 3360, 2520, 1680, 1260, 840, 504, 0};
   localparam int CODES [12] = '{1, 5, 10, 15, 20, 23, 25, 28, 30, 33, 37, 40};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fsync_in = 1'b0;
   logic          tol_wide = 1'b0;
   logic          err_clr = 1'b0;
   logic          rate_valid;
   logic [5:0]    rate_code;
   logic          clk_err;
   logic [CW-1:0] period_cnt;

   int checks = 0;
   int fails  = 0;

   // reference model state
   bit m_armed = 0;
   int m_gap   = 0;
   bit m_prev  = 0;
   bit m_valid = 0;
   int m_code  = 0;
   int m_cand  = 0;
   int m_last  = 0;
   bit m_err   = 0;
   int m_period = 0;

   always #10 clk = ~clk;

   fsync_rate_sorter #(
      .REF_HZ (REF),
      .CNT_W  (CW)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync_in   (fsync_in),
      .tol_wide   (tol_wide),
      .err_clr    (err_clr),
      .rate_valid (rate_valid),
      .rate_code  (rate_code),
      .clk_err    (clk_err),
      .period_cnt (period_cnt)
   );

   function automatic int exp_code(int p, bit w);
      for (int i = 0; i < 12; i++) begin
         longint lo;
         longint hi;
         if (w && i == 11) continue;
         lo = w ? WLO[i] : NLO[i];
         hi = w ? WHI[i] : NHI[i];
         if (longint'(p) * lo * 10 <= REF && REF <= longint'(p) * hi * 10) return CODES[i];
      end
      return 0;
   endfunction

   function automatic void m_event(int p);
      int pp;
      int c;
      pp = (p >= MAXC) ? MAXC : p;
      c  = (pp >= MAXC) ? 0 : exp_code(pp, tol_wide);
      m_period = pp;
      if (c == 0) begin
         m_valid = 0; m_code = 0; m_cand = 0; m_err = 1;
      end else if (c == m_cand) begin
         if (m_last != 0 && m_last != c) m_err = 1;
         m_last = c; m_valid = 1; m_code = c;
      end else begin
         m_cand = c; m_valid = 0; m_code = 0;
      end
   endfunction

   task automatic cyc(input bit v);
      bit rising;
      fsync_in = v;
      rising = v && !m_prev;
      m_prev = v;
      m_gap++;
      @(negedge clk);
      if (rising) begin
         if (m_armed) m_event(m_gap);
         m_armed = 1;
         m_gap = 0;
      end else if (m_armed && m_gap == MAXC) begin
         m_event(MAXC);
      end
   endtask

   task automatic frames(input int p, input int n);
      for (int k = 0; k < n; k++) begin
         for (int j = 0; j < p; j++) cyc(j < p / 2);
      end
   endtask

   task automatic clear_err();
      err_clr = 1'b1;
      cyc(1'b0);
      err_clr = 1'b0;
      m_err = 0;
   endtask

   task automatic cmp(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      cmp(req, "rate_valid", int'(rate_valid), int'(m_valid));
      cmp(req, "rate_code",  int'(rate_code),  m_code);
      cmp(req, "clk_err",    int'(clk_err),    int'(m_err));
      cmp(req, "period_cnt", int'(period_cnt), m_period);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");

      // R2: the first edge only arms the counter
      frames(512, 1);
      check_all("R2 first edge arms");
      cmp("R2", "period after first edge", int'(period_cnt), 0);

      // R6: two matching periods lock, 48 kHz -> code 20 (R3)
      frames(512, 2);
      check_all("R6 lock at 48k");
      cmp("R3", "48k narrow code", int'(rate_code), 20);

      // R6: a single period at a new rate drops the lock
      frames(256, 2);
      check_all("R6 mismatch unlocks");
      // R8: relock at a different rate sets the error flag
      frames(256, 1);
      check_all("R8 relock new rate");
      cmp("R8", "error after rate change", int'(clk_err), 1);

      // R9: clear pulse
      clear_err();
      check_all("R9 cleared");
      frames(256, 3);
      check_all("R9 stays clear on same rate");

      // R3 boundary counts around 768 kHz narrow window
      frames(32, 3);
      check_all("R3 768k lowest count");
      frames(35, 3);
      check_all("R3 768k highest count");
      frames(36, 3);
      check_all("R7 just outside 768k");
      frames(31, 3);
      check_all("R7 below 768k floor");
      clear_err();

      // R10 and R5: same period, narrow rejects, wide accepts
      tol_wide = 1'b0;
      frames(495, 3);
      check_all("R10 narrow rejects 495");
      tol_wide = 1'b1;
      frames(495, 3);
      check_all("R10 wide accepts 495");
      cmp("R5", "48k wide code", int'(rate_code), 20);
      clear_err();

      // R5: 4.8 kHz in wide mode -> code 37
      frames(5120, 3);
      check_all("R5 4.8k wide");
      // R5: 3 kHz window absent in wide mode
      frames(8192, 2);
      check_all("R5 no 3k in wide");
      cmp("R5", "3k wide invalid", int'(rate_valid), 0);
      clear_err();

      // R3: 3 kHz in narrow mode -> code 40
      tol_wide = 1'b0;
      frames(8192, 3);
      check_all("R3 3k narrow");
      cmp("R3", "3k narrow code", int'(rate_code), 40);

      // R4: random fast periods near window edges in both modes
      for (int it = 0; it < 40; it++) begin
         int b;
         int lo;
         int hi;
         int p;
         b = int'($urandom % 4);
         tol_wide = ($urandom % 2) != 0;
         lo = int'(REF / (longint'(tol_wide ? WHI[b] : NHI[b]) * 10));
         hi = int'(REF / (longint'(tol_wide ? WLO[b] : NLO[b]) * 10));
         p  = lo - 2 + int'($urandom % (hi - lo + 5));
         frames(p, 2 + int'($urandom % 2));
         check_all("R4 random period");
         if ($urandom % 5 == 0) begin
            clear_err();
            check_all("R9 random clear");
         end
      end

      // R11 and R7: frame-sync stops, counter saturates
      tol_wide = 1'b0;
      frames(512, 3);
      clear_err();
      for (int j = 0; j < MAXC + 20; j++) cyc(1'b0);
      check_all("R11 saturation");
      cmp("R11", "saturated period", int'(period_cnt), MAXC);
      cmp("R7", "error after stop", int'(clk_err), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule